// File: doc/BRIEF.md
# Low-Power Entry and Exit Deadline Monitor

This block watches a memory controller from the outside. It checks that the DRAM is put into a power-saving state soon enough once the system has no more work. It also checks that the DRAM is woken soon enough once new work shows up. It observes the number of outstanding requests, a one-cycle strobe for each new request, and the power mode the DRAM is currently in. Two run-time deadlines are given in clock cycles, one for going to sleep and one for waking up.

Three sleep modes count as compliant: clock stop, power down and self refresh. A missed deadline produces a single-cycle error pulse on a dedicated output, one output per deadline. The monitor then stays quiet until the expected transition happens. A four-state status output shows which phase the monitor believes the system is in. Setting a deadline to zero turns that check off.

Top module: `pwr_save_monitor`

## Requirements
- R1: While and after reset, `mon_state` reads 2'b00 (busy) and both error outputs are low.
- R2: `pwr_mode` is decoded as 2'b00 awake, 2'b01 clock stop, 2'b10 power down, 2'b11 self refresh. `mon_state` is encoded as 2'b00 busy, 2'b01 waiting for sleep, 2'b10 asleep, 2'b11 waiting for wake.
- R3: In busy state, when `pending_cnt` is zero, `req_strobe` is low and the DRAM is awake, the next state is waiting-for-sleep. From waiting-for-sleep, a change to any of the three sleep modes moves the monitor to asleep with no error.
- R4: If the monitor is still waiting for sleep at the `sleep_limit`-th clock edge after entering that state, `late_sleep` is high for exactly the one cycle that follows that edge.
- R5: After an error pulse, no further pulse of the same kind is produced until the monitor leaves the waiting state.
- R6: In waiting-for-sleep with the DRAM awake, a `req_strobe` or a nonzero `pending_cnt` returns the monitor to busy with no error.
- R7: In asleep state, a `req_strobe` moves the monitor to waiting-for-wake. If the DRAM is still asleep at the `wake_limit`-th edge after that, `late_wake` pulses for one cycle.
- R8: In waiting-for-wake or asleep state, a return of `pwr_mode` to 2'b00 moves the monitor to busy. If this happens before the deadline, no error is produced.
- R9: A limit value of zero disables the matching check. No pulse is produced however long the wait lasts.
- R10: If a sleep mode is observed while busy, the monitor moves to asleep. If `req_strobe` is also high in that cycle, it moves to waiting-for-wake instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pending_cnt | input | CNT_W | Number of outstanding requests |
| req_strobe | input | 1 | One-cycle pulse per new request from the system |
| pwr_mode | input | 2 | Observed DRAM power mode (R2 encoding) |
| sleep_limit | input | TMR_W | Cycles allowed to reach a sleep mode; 0 disables |
| wake_limit | input | TMR_W | Cycles allowed to wake after a request; 0 disables |
| late_sleep | output | 1 | One-cycle pulse on a missed sleep deadline |
| late_wake | output | 1 | One-cycle pulse on a missed wake deadline |
| mon_state | output | 2 | Current monitor phase (R2 encoding) |

## Verification
The bench keeps the default widths: an 8-bit request count and 16-bit limits. It drives the limits at run time with small values, 4 cycles for sleep and 3 for wake, so that both deadlines expire within a few cycles. That keeps lateness, on-time transitions and cancellations all within a short run. Changing the limits to zero in the middle of the run exercises the disabled case over 20-cycle waits. Long stalls after a pulse show that the monitor does not fire again.

// File: rtl/pwr_save_monitor.sv
module pwr_save_monitor #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] pending_cnt,
  input  logic             req_strobe,
  input  logic [1:0]       pwr_mode,
  input  logic [TMR_W-1:0] sleep_limit,
  input  logic [TMR_W-1:0] wake_limit,
  output logic             late_sleep,
  output logic             late_wake,
  output logic [1:0]       mon_state
);

  localparam logic [1:0] ST_BUSY  = 2'b00;
  localparam logic [1:0] ST_SLEEP = 2'b01;
  localparam logic [1:0] ST_LOW   = 2'b10;
  localparam logic [1:0] ST_WAKE  = 2'b11;

  logic [1:0]       state;
  logic [TMR_W-1:0] tmr;
  logic             fired;

  wire             asleep  = pwr_mode != 2'b00;
  wire             no_work = pending_cnt == '0;
  wire [TMR_W-1:0] lim     = (state == ST_SLEEP) ? sleep_limit : wake_limit;
  wire             hit     = (lim != '0) && !fired && (tmr == lim - 1'b1);

  assign mon_state = state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_BUSY;
      tmr        <= '0;
      fired      <= 1'b0;
      late_sleep <= 1'b0;
      late_wake  <= 1'b0;
    end else begin
      late_sleep <= 1'b0;
      late_wake  <= 1'b0;
      case (state)
        ST_BUSY, ST_SLEEP: begin
          if (asleep) begin
            state <= req_strobe ? ST_WAKE : ST_LOW;
            tmr   <= '0;
            fired <= 1'b0;
          end else if (state == ST_BUSY) begin
            if (no_work && !req_strobe) begin
              state <= ST_SLEEP;
              tmr   <= '0;
              fired <= 1'b0;
            end
          end else if (req_strobe || !no_work) begin
            state <= ST_BUSY;
          end else if (!fired) begin
            tmr <= tmr + 1'b1;
            if (hit) begin
              late_sleep <= 1'b1;
              fired      <= 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (!asleep) begin
            state <= ST_BUSY;
          end else if (req_strobe) begin
            state <= ST_WAKE;
            tmr   <= '0;
            fired <= 1'b0;
          end
        end
        default: begin
          if (!asleep) begin
            state <= ST_BUSY;
          end else if (!fired) begin
            tmr <= tmr + 1'b1;
            if (hit) begin
              late_wake <= 1'b1;
              fired     <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_sleep_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    late_sleep |=> !late_sleep);
  assert_sleep_pulse_in_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    late_sleep |-> mon_state == ST_SLEEP);
  assert_wake_pulse_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    late_wake |-> mon_state == ST_WAKE);
  assert_wake_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    late_wake |=> !late_wake);
  assert_cancel_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_state == ST_SLEEP && !asleep && req_strobe) |=> (mon_state == ST_BUSY && !late_sleep));
  assert_any_mode_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_state == ST_SLEEP && asleep && !req_strobe) |=> (mon_state == ST_LOW && !late_sleep));
  assert_zero_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (late_sleep && mon_state == ST_SLEEP) |-> $past(sleep_limit) != '0);
  assert_wake_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_state == ST_WAKE && !asleep) |=> (mon_state == ST_BUSY && !late_wake));

endmodule

// File: tb/pwr_save_monitor_tb.sv
module pwr_save_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pending_cnt = 8'd0;
  logic        req_strobe = 1'b0;
  logic [1:0]  pwr_mode = 2'b00;
  logic [15:0] sleep_limit = 16'd4;
  logic [15:0] wake_limit = 16'd3;
  logic        late_sleep, late_wake;
  logic [1:0]  mon_state;

  int tests = 0, fails = 0, cycles = 0;
  int n_sleep = 0, n_wake = 0;
  string tag = "R1";

  int m_st = 0, m_cnt = 0;
  bit m_fired = 0, m_ls = 0, m_lw = 0;

  always #10 clk = ~clk;

  pwr_save_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .pending_cnt(pending_cnt), .req_strobe(req_strobe),
    .pwr_mode(pwr_mode), .sleep_limit(sleep_limit), .wake_limit(wake_limit),
    .late_sleep(late_sleep), .late_wake(late_wake), .mon_state(mon_state)
  );

  task automatic chk(string t, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  // Behavioural reference: phase number, cycles waited, one-shot flag.
  always @(posedge clk) begin
    bit sl;
    int lim;
    sl = pwr_mode != 0;
    m_ls = 0;
    m_lw = 0;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_fired = 0;
    end else if ((m_st == 0 || m_st == 1) && sl) begin
      m_st = req_strobe ? 3 : 2; m_cnt = 0; m_fired = 0;
    end else if (m_st == 0) begin
      if (pending_cnt == 0 && !req_strobe) begin m_st = 1; m_cnt = 0; m_fired = 0; end
    end else if (m_st == 1) begin
      if (req_strobe || pending_cnt != 0) m_st = 0;
      else if (!m_fired) begin
        m_cnt++;
        if (sleep_limit != 0 && m_cnt == sleep_limit) begin m_ls = 1; m_fired = 1; end
      end
    end else if (m_st == 2) begin
      if (!sl) m_st = 0;
      else if (req_strobe) begin m_st = 3; m_cnt = 0; m_fired = 0; end
    end else begin
      lim = wake_limit;
      if (!sl) m_st = 0;
      else if (!m_fired) begin
        m_cnt++;
        if (lim != 0 && m_cnt == lim) begin m_lw = 1; m_fired = 1; end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk({tag, " state"}, mon_state, m_st);
      chk({tag, " late_sleep"}, late_sleep, m_ls);
      chk({tag, " late_wake"}, late_wake, m_lw);
      n_sleep += late_sleep;
      n_wake  += late_wake;
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe();
    req_strobe = 1'b1;
    step(1);
    req_strobe = 1'b0;
  endtask

  initial begin
    step(3);
    chk("R1 reset state", mon_state, 0);
    chk("R1 reset pulses", late_sleep | late_wake, 0);
    rst_n = 1'b1;

    tag = "R3"; pending_cnt = 8'd3; step(3);
    chk("R3 busy with work", mon_state, 0);
    pending_cnt = 0; step(3);
    pwr_mode = 2'b01; step(2);
    chk("R3 clock stop accepted", mon_state, 2);
    tag = "R2"; pwr_mode = 2'b00; step(2);
    chk("R2 awake decoded", mon_state, 1);

    tag = "R4"; n_sleep = 0; step(4);
    tag = "R5"; step(12);
    chk("R5 single sleep pulse", n_sleep, 1);
    chk("R4 still waiting", mon_state, 1);
    pwr_mode = 2'b10; step(2);
    chk("R3 power down accepted", mon_state, 2);

    tag = "R7"; n_wake = 0; strobe(); step(10);
    chk("R7 single wake pulse", n_wake, 1);
    tag = "R8"; pwr_mode = 2'b00; step(1);
    chk("R8 back to busy", mon_state, 0);

    tag = "R6"; n_sleep = 0; step(2); strobe(); step(1);
    pending_cnt = 8'd1; step(2); pending_cnt = 0; step(3);
    chk("R6 cancel no pulse", n_sleep, 0);

    tag = "R8"; pwr_mode = 2'b11; step(2); n_wake = 0; strobe(); step(1);
    pwr_mode = 2'b00; step(3);
    chk("R8 on-time wake", n_wake, 0);

    tag = "R9"; sleep_limit = 0; wake_limit = 0; n_sleep = 0; n_wake = 0; step(20);
    pwr_mode = 2'b01; step(1); strobe(); step(20);
    chk("R9 zero disables", n_sleep + n_wake, 0);
    pwr_mode = 2'b00; sleep_limit = 16'd4; wake_limit = 16'd3; step(2);

    tag = "R10"; pending_cnt = 8'd5; step(2); pwr_mode = 2'b01; step(1);
    chk("R10 sleep while busy", mon_state, 2);
    pwr_mode = 2'b00; step(2); pwr_mode = 2'b10; req_strobe = 1'b1; step(1);
    req_strobe = 1'b0;
    chk("R10 sleep with strobe", mon_state, 3);
    pwr_mode = 2'b00; pending_cnt = 0; step(3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule